// File: doc/BRIEF.md
# Offset-Adjusted Compare Timer

This block turns a free-running 64-bit physical counter into a virtual count by subtracting a programmable offset. It raises an interrupt whenever a programmed compare value is less than or equal to that virtual count. A host programs three registers through a simple write port: the offset, the compare value and a control word. It reads any of them back through a combinational read port. The control word also carries a read-only status bit that shows whether the timer condition currently holds.

The fire decision is made entirely in the virtual domain. The offset is subtracted from the physical count and the result is compared against the compare value. The compare value is never added to the offset. Because of this, no carry out of 64 bits can corrupt the decision. A compare value of all ones stays silent unless the virtual count itself reaches all ones, whatever the offset.

Both the interrupt and the status bit are registered. A change to a register, or to the physical count, shows up on the outputs one clock after the edge that captured it.

Top module: `vtimer_cmp`

## Requirements
- R1: The virtual count is the physical count minus the offset register, wrapping modulo 2^64.
- R2: The timer condition holds exactly when the compare register is less than or equal to the virtual count, using an unsigned 64-bit comparison.
- R3: `irq_o` is high only when the enable bit (control bit 0) is 1, the mask bit (control bit 1) is 0 and the condition holds.
- R4: A compare value of all ones never raises the interrupt while the virtual count is below all ones, including offsets where compare plus offset would pass 2^64.
- R5: Control bit 2 is read-only; writing it has no effect. Control bits above 2 read as zero.
- R6: Control bit 2 reads 1 when enable is set and the condition holds, whatever the mask. It reads 0 whenever enable is clear.
- R7: `irq_o` and the status bit reflect the registers and `phys_cnt_i` as they stood at the previous rising clock edge. A register write therefore shows up one cycle after the write is captured.
- R8: After reset the offset, compare and control registers are zero, and `irq_o` and the status bit are 0.
- R9: Register address 0 is the offset, 1 is the compare value and 2 is the control word. Address 3 reads as zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 64 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 64 | Register read data (combinational) |
| phys_cnt_i | input | 64 | Free-running physical count |
| irq_o | output | 1 | Timer interrupt, level |

## Verification
The assertions take for granted that `phys_cnt_i` and the write port are stable around each rising edge. They also assume that the physical count may jump by any amount, with no monotonic stepping. The stimulus drives every input on the falling edge and loads arbitrary 64-bit physical values directly. It sweeps offset, compare and count over the extremes: zero, one, the sign boundary, and one and two below all ones. This exercises wrap in the subtraction and the all-ones compare case without ever changing an input near the sampling edge.

// File: rtl/vt_pkg.sv
package vt_pkg;
  localparam int CNT_W  = 64;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_OFFSET  = 2'd0,
    RA_COMPARE = 2'd1,
    RA_CONTROL = 2'd2,
    RA_NONE    = 2'd3
  } reg_addr_e;

  localparam int CB_ENABLE = 0;
  localparam int CB_MASK   = 1;
  localparam int CB_STATUS = 2;
endpackage

// File: rtl/vt_regs.sv
module vt_regs
  import vt_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      off_q,
  output logic [W-1:0]      cmp_q,
  output logic              en_q,
  output logic              mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      cmp_q  <= '0;
      en_q   <= 1'b0;
      mask_q <= 1'b0;
    end else if (wr_en) begin
      unique case (reg_addr_e'(wr_addr))
        RA_OFFSET:  off_q <= wr_data;
        RA_COMPARE: cmp_q <= wr_data;
        RA_CONTROL: begin
          en_q   <= wr_data[CB_ENABLE];
          mask_q <= wr_data[CB_MASK];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vt_ge_cmp.sv
// Unsigned a >= b, built from equal-width slices resolved from the top down.
module vt_ge_cmp #(
  parameter int W  = 64,
  parameter int SW = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         ge
);
  localparam int NS = W / SW;

  logic [NS-1:0] sl_gt;
  logic [NS-1:0] sl_eq;

  for (genvar i = 0; i < NS; i++) begin : g_slice
    logic [SW-1:0] sa, sb;
    assign sa       = a[i*SW +: SW];
    assign sb       = b[i*SW +: SW];
    assign sl_gt[i] = sa > sb;
    assign sl_eq[i] = sa == sb;
  end

  always_comb begin
    logic decided;
    decided = 1'b0;
    ge      = 1'b1;
    for (int i = NS - 1; i >= 0; i--) begin
      if (!decided && !sl_eq[i]) begin
        decided = 1'b1;
        ge      = sl_gt[i];
      end
    end
  end
endmodule

// File: rtl/vtimer_cmp.sv
module vtimer_cmp
  import vt_pkg::*;
#(
  parameter int W        = CNT_W,
  parameter int SLICE_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      rd_data,
  input  logic [W-1:0]      phys_cnt_i,
  output logic              irq_o
);
  logic [W-1:0] off_q, cmp_q, vcnt;
  logic         en_q, mask_q, cond_met;
  logic         stat_q, irq_q;

  vt_regs #(.W(W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .off_q  (off_q),
    .cmp_q  (cmp_q),
    .en_q   (en_q),
    .mask_q (mask_q)
  );

  // Virtual domain: subtraction wraps modulo 2^W; compare value is never summed.
  assign vcnt = phys_cnt_i - off_q;

  vt_ge_cmp #(.W(W), .SW(SLICE_W)) u_ge (
    .a (vcnt),
    .b (cmp_q),
    .ge(cond_met)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= en_q & cond_met;
      irq_q  <= en_q & ~mask_q & cond_met;
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    rd_data = '0;
    unique case (reg_addr_e'(rd_addr))
      RA_OFFSET:  rd_data = off_q;
      RA_COMPARE: rd_data = cmp_q;
      RA_CONTROL: begin
        rd_data[CB_ENABLE] = en_q;
        rd_data[CB_MASK]   = mask_q;
        rd_data[CB_STATUS] = stat_q;
      end
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/vt_checker.sv
module vt_checker #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] phys_cnt_i,
  input logic [W-1:0] off_q,
  input logic [W-1:0] cmp_q,
  input logic         en_q,
  input logic         mask_q,
  input logic         stat_q,
  input logic         irq_o
);
  logic [W-1:0] vc;
  assign vc = phys_cnt_i - off_q;

  assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(en_q) && !$past(mask_q)));

  assert_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !mask_q && (cmp_q <= vc)) |=> irq_o);

  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_q > vc) |=> (!irq_o && !stat_q));

  assert_all_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cmp_q) && !(&vc)) |=> !irq_o);

  assert_status_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !stat_q);

  assert_irq_implies_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> stat_q);
endmodule

bind vtimer_cmp vt_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .phys_cnt_i(phys_cnt_i),
  .off_q     (off_q),
  .cmp_q     (cmp_q),
  .en_q      (en_q),
  .mask_q    (mask_q),
  .stat_q    (stat_q),
  .irq_o     (irq_o)
);

// File: tb/sim_vtimer_cmp.sv
`timescale 1ns/1ps
module sim_vtimer_cmp;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic [W-1:0] phys = '0;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vtimer_cmp u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .phys_cnt_i(phys), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic cond(input logic [W-1:0] p, input logic [W-1:0] o, input logic [W-1:0] c);
    logic [W-1:0] v;
    v = p - o;
    return c <= v;
  endfunction

  task automatic rd_ctl(output logic [W-1:0] v);
    rd_addr = 2'd2; #1; v = rd_data;
  endtask

  logic [W-1:0] vals [7];
  logic [W-1:0] rv;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    vals[0] = 64'd0;
    vals[1] = 64'd1;
    vals[2] = 64'h7FFF_FFFF_FFFF_FFFF;
    vals[3] = 64'h8000_0000_0000_0000;
    vals[4] = 64'hFFFF_FFFF_FFFF_FFFD;
    vals[5] = 64'hFFFF_FFFF_FFFF_FFFE;
    vals[6] = 64'hFFFF_FFFF_FFFF_FFFF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: reset state
    chk("R8 irq", W'(irq), 0);
    rd_addr = 2'd0; #1; chk("R8 offset", rd_data, 0);
    rd_addr = 2'd1; #1; chk("R8 compare", rd_data, 0);
    rd_ctl(rv); chk("R8 control", rv, 0);

    // R9: readback of addressed registers, address 3 inert
    wr(2'd0, 64'h1234_5678_9ABC_DEF0);
    wr(2'd1, 64'h0FED_CBA9_8765_4321);
    wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_addr = 2'd0; #1; chk("R9 offset readback", rd_data, 64'h1234_5678_9ABC_DEF0);
    rd_addr = 2'd1; #1; chk("R9 compare readback", rd_data, 64'h0FED_CBA9_8765_4321);
    rd_addr = 2'd3; #1; chk("R9 addr3 reads zero", rd_data, 0);
    rd_ctl(rv); chk("R9 addr3 write ignored", rv, 0);

    // R5: status bit not writable; upper bits read zero
    phys = 64'd10; wr(2'd0, 64'd0); wr(2'd1, 64'd100);
    wr(2'd2, 64'hFFFF_FFFF_FFFF_FFF5); // en=1 mask=0 status bit written 1
    @(negedge clk);
    rd_ctl(rv); chk("R5 status write ignored", rv, 64'h1);
    chk("R5 irq", W'(irq), 0);

    // R7: latency of a control write
    wr(2'd2, 64'h0);
    phys = 64'd200; @(negedge clk); @(negedge clk);
    chk("R7 idle before enable", W'(irq), 0);
    wr(2'd2, 64'h1);
    chk("R7 not yet one cycle after capture edge", W'(irq), 0);
    @(negedge clk);
    chk("R7 asserted next cycle", W'(irq), 1);
    // R7: physical count step shows one cycle later
    phys = 64'd50; @(negedge clk);
    chk("R7 phys drop clears", W'(irq), 0);

    // R1/R2/R3/R6: sweep offset, compare, count and control over extremes
    for (int io = 0; io < 7; io++) begin
      for (int ic = 0; ic < 7; ic++) begin
        for (int ip = 0; ip < 7; ip++) begin
          for (int m = 0; m < 3; m++) begin
            logic en, mk, c;
            en = (m != 2); mk = (m == 1);
            phys = vals[ip];
            wr(2'd0, vals[io]);
            wr(2'd1, vals[ic]);
            wr(2'd2, {62'b0, mk, en});
            @(negedge clk);
            c = cond(vals[ip], vals[io], vals[ic]);
            chk("R2 R3 irq sweep", W'(irq), W'(en & ~mk & c));
            rd_ctl(rv);
            chk("R6 status sweep", rv, {61'b0, en & c, mk, en});
          end
        end
      end
    end

    // R1: wrap in the subtraction: phys 5, offset 10 gives virtual all ones minus 4
    phys = 64'd5; wr(2'd0, 64'd10); wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFB); wr(2'd2, 64'h1);
    @(negedge clk);
    chk("R1 wrapped virtual meets compare", W'(irq), 1);
    wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFC);
    @(negedge clk);
    chk("R1 wrapped virtual below compare", W'(irq), 0);

    // R4: all-ones compare with offsets where compare+offset would wrap
    wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    for (int k = 1; k < 20; k++) begin
      wr(2'd0, 64'(k * 37));
      phys = 64'(k * 1000);
      @(negedge clk);
      chk("R4 all-ones compare silent", W'(irq), 0);
    end
    // reaching all ones in virtual count meets the condition
    wr(2'd0, 64'd1); phys = 64'd0; @(negedge clk);
    chk("R4 virtual all ones fires", W'(irq), 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule